// File: doc/BRIEF.md
# Linked-List DMA Descriptor Fetcher

This block steers a single DMA channel through a chain of transfer descriptors kept in system memory. Each descriptor is four consecutive 32-bit words. Word 0 holds the control fields and the transfer count. Word 1 holds the peripheral address, word 2 the memory address and word 3 the address of the next descriptor. Software first turns on linked operation and leaves the channel count at zero. It then writes the address of the first descriptor into the pointer register and raises the channel enable.

The block reads the four words one at a time over a single-beat read port. It then hands the control field, count and both addresses to a transfer engine with a one-cycle start pulse. When the engine reports that its count has run out, the block either fetches the descriptor named by the next pointer or finishes. If it finishes, it raises a sticky completion flag that software clears with a write-one strobe.

Only the last descriptor of a chain raises the completion flag. Dropping the channel enable at any point abandons the chain without a start pulse or a completion.

Top module: `desc_chain_fetch`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `mem_req`, `eng_start` and `done_irq` are 0 and the engine outputs read 0.
- R2: A chain starts only on a rising edge of `chan_en` while `link_en` is 1 and `chan_cnt` is 0. Under any other condition no memory read is issued. A chain does not restart while `chan_en` simply stays high after it ends.
- R3: A descriptor is read as four words at base, base+4, base+8 and base+12, in that order. While `mem_ack` is low, `mem_req` stays high and `mem_addr` holds its value.
- R4: The two low bits of every pointer are ignored, both the software pointer and the next pointer in word 3. A next pointer whose bits [31:2] are all zero ends the chain.
- R5: `eng_start` is high for exactly one cycle, the cycle after the fourth word is acknowledged. In that cycle and until the next start, `eng_cnt` equals word 0 bits [15:0], `eng_ctrl` equals word 0 bits [31:16], `eng_paddr` equals word 1 and `eng_maddr` equals word 2.
- R6: When `eng_cnt_zero` is seen during a transfer and the next pointer is non-zero, the cycle after it reads word 0 of the next descriptor.
- R7: When `eng_cnt_zero` is seen during a transfer and the next pointer is zero, `done_irq` rises in the following cycle and no further read is issued. Intermediate descriptors never raise it.
- R8: `done_irq` stays high until a cycle with `done_clr` high. If completion and `done_clr` fall in the same cycle, the flag is set.
- R9: If `chan_en` is low during a fetch or a transfer, the block is idle in the next cycle. No start pulse follows, and `done_irq` is not set.
- R10: `eng_cnt_zero` has no effect while the block is idle or fetching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Linked operation enabled |
| chan_en | input | 1 | Channel enable |
| chan_cnt | input | CNT_W | Channel count register value; must be 0 to start a chain |
| ptr_wr | input | 1 | Write strobe for the first-descriptor pointer |
| ptr_wdata | input | AW | First-descriptor address |
| done_clr | input | 1 | Write-one-to-clear strobe for the completion flag |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | AW | Word-aligned read address |
| mem_ack | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata | input | DW | Read data |
| eng_start | output | 1 | One-cycle start pulse to the transfer engine |
| eng_ctrl | output | DW-CNT_W | Control field of word 0 |
| eng_cnt | output | CNT_W | Transfer count of word 0 |
| eng_paddr | output | DW | Peripheral address |
| eng_maddr | output | DW | Memory address |
| eng_cnt_zero | input | 1 | Engine reports its count has reached zero |
| done_irq | output | 1 | Sticky chain-complete flag |

## Verification
Chain completion and the software clear of the completion flag can land in the same cycle, and the set must win. The bench provokes this by holding `done_clr` high through an entire single-descriptor run, so the clear strobe is certainly present on the cycle the engine reports zero. It then expects `done_irq` to be high for exactly one cycle, cleared by the still-present strobe one cycle later. A second coincidence, a channel disable against an engine zero report or a pending read, is judged by the reference model, which expects idle and no flag.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Descriptor layout: word order is decoded by the engine hand-off.
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
  localparam int unsigned WI_CTRL    = 0;
  localparam int unsigned WI_PADDR   = 1;
  localparam int unsigned WI_MADDR   = 2;
  localparam int unsigned WI_NEXT    = 3;
  localparam int unsigned PTR_LSBS   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2
  } fetch_state_e;

endpackage

// File: rtl/dcf_ptr_unit.sv
module dcf_ptr_unit
  import dcf_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_wr,
  input  logic [AW-1:0]    ptr_wdata,
  input  logic             load_first,
  input  logic             load_next,
  input  logic [AW-1:0]    next_ptr,
  input  logic [IDX_W-1:0] word_idx,
  output logic [AW-1:0]    fetch_addr,
  output logic             next_is_null
);

  function automatic logic [AW-1:0] align_ptr(input logic [AW-1:0] p);
    return {p[AW-1:PTR_LSBS], {PTR_LSBS{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] base,
                                              input logic [IDX_W-1:0] idx);
    return base + (AW'(idx) << PTR_LSBS);
  endfunction

  function automatic logic ptr_null(input logic [AW-1:0] p);
    return (p[AW-1:PTR_LSBS] == '0);
  endfunction

  logic [AW-1:0] sw_ptr_q;
  logic [AW-1:0] cur_base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_ptr_q <= '0;
    end else if (ptr_wr) begin
      sw_ptr_q <= ptr_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_base_q <= '0;
    end else if (load_first) begin
      cur_base_q <= align_ptr(sw_ptr_q);
    end else if (load_next) begin
      cur_base_q <= align_ptr(next_ptr);
    end
  end

  assign fetch_addr   = word_addr(cur_base_q, word_idx);
  assign next_is_null = ptr_null(next_ptr);

endmodule

// File: rtl/dcf_desc_regs.sv
module dcf_desc_regs
  import dcf_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic [DW-1:0]    cap_data,
  input  logic             launch_evt,
  output logic [DW-1:0]    out_word0,
  output logic [DW-1:0]    out_paddr,
  output logic [DW-1:0]    out_maddr,
  output logic [DW-1:0]    next_word
);

  logic [DESC_WORDS-1:0][DW-1:0] stage;

  // Staging words, one register per descriptor word.
  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_stage
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (cap_evt && (cap_idx == IDX_W'(g))) begin
        word_q <= cap_data;
      end
    end
    assign stage[g] = word_q;
  end

  // Engine-facing copy, refreshed only when a full descriptor is in.
  logic [DW-1:0] o_word0_q, o_paddr_q, o_maddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_word0_q <= '0;
      o_paddr_q <= '0;
      o_maddr_q <= '0;
    end else if (launch_evt) begin
      o_word0_q <= stage[WI_CTRL];
      o_paddr_q <= stage[WI_PADDR];
      o_maddr_q <= stage[WI_MADDR];
    end
  end

  assign out_word0 = o_word0_q;
  assign out_paddr = o_paddr_q;
  assign out_maddr = o_maddr_q;
  assign next_word = stage[WI_NEXT];

endmodule

// File: rtl/dcf_ctrl.sv
module dcf_ctrl
  import dcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             arm_ok,
  input  logic             mem_ack,
  input  logic             eng_cnt_zero,
  input  logic             next_is_null,
  output fetch_state_e     state,
  output logic [IDX_W-1:0] word_idx,
  output logic             open_evt,
  output logic             cap_evt,
  output logic             launch_evt,
  output logic             follow_evt,
  output logic             end_evt,
  output logic             abort_evt,
  output logic             eng_start
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  fetch_state_e     state_q, state_d;
  logic             en_q;
  logic             xfer_done;
  logic [IDX_W-1:0] idx_q;
  logic             start_q;

  assign open_evt   = (state_q == ST_IDLE) && chan_en && !en_q && arm_ok;
  assign abort_evt  = (state_q != ST_IDLE) && !chan_en;
  assign cap_evt    = (state_q == ST_FETCH) && chan_en && mem_ack;
  assign launch_evt = cap_evt && (idx_q == LAST_IDX);
  assign xfer_done  = (state_q == ST_XFER) && chan_en && eng_cnt_zero;
  assign follow_evt = xfer_done && !next_is_null;
  assign end_evt    = xfer_done && next_is_null;

  always_comb begin
    state_d = state_q;
    if (abort_evt) begin
      state_d = ST_IDLE;
    end else if (open_evt || follow_evt) begin
      state_d = ST_FETCH;
    end else if (launch_evt) begin
      state_d = ST_XFER;
    end else if (end_evt) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      idx_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= chan_en;
      start_q <= launch_evt;
      if (open_evt || follow_evt) begin
        idx_q <= '0;
      end else if (cap_evt && !launch_evt) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign state     = state_q;
  assign word_idx  = idx_q;
  assign eng_start = start_q;

endmodule

// File: rtl/dcf_done_flag.sv
module dcf_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_strobe,
  output logic flag
);

  logic flag_q;

  // Set has priority over a coincident clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set_evt) begin
      flag_q <= 1'b1;
    end else if (clr_strobe) begin
      flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/desc_chain_fetch.sv
module desc_chain_fetch
  import dcf_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_en,
  input  logic               chan_en,
  input  logic [CNT_W-1:0]   chan_cnt,
  input  logic               ptr_wr,
  input  logic [AW-1:0]      ptr_wdata,
  input  logic               done_clr,
  output logic               mem_req,
  output logic [AW-1:0]      mem_addr,
  input  logic               mem_ack,
  input  logic [DW-1:0]      mem_rdata,
  output logic               eng_start,
  output logic [DW-CNT_W-1:0] eng_ctrl,
  output logic [CNT_W-1:0]   eng_cnt,
  output logic [DW-1:0]      eng_paddr,
  output logic [DW-1:0]      eng_maddr,
  input  logic               eng_cnt_zero,
  output logic               done_irq
);

  localparam int unsigned CTRL_W = DW - CNT_W;

  // Named internal events, also observed by the bound checker.
  fetch_state_e     state;
  logic [IDX_W-1:0] word_idx;
  logic             open_evt, cap_evt, launch_evt, follow_evt, end_evt, abort_evt;
  logic             arm_ok;
  logic             next_is_null;
  logic [DW-1:0]    out_word0;
  logic [DW-1:0]    next_word;
  logic [AW-1:0]    fetch_addr;

  assign arm_ok = link_en && (chan_cnt == '0);

  dcf_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .chan_en      (chan_en),
    .arm_ok       (arm_ok),
    .mem_ack      (mem_ack),
    .eng_cnt_zero (eng_cnt_zero),
    .next_is_null (next_is_null),
    .state        (state),
    .word_idx     (word_idx),
    .open_evt     (open_evt),
    .cap_evt      (cap_evt),
    .launch_evt   (launch_evt),
    .follow_evt   (follow_evt),
    .end_evt      (end_evt),
    .abort_evt    (abort_evt),
    .eng_start    (eng_start)
  );

  dcf_ptr_unit #(.AW(AW)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .ptr_wr       (ptr_wr),
    .ptr_wdata    (ptr_wdata),
    .load_first   (open_evt),
    .load_next    (follow_evt),
    .next_ptr     (next_word[AW-1:0]),
    .word_idx     (word_idx),
    .fetch_addr   (fetch_addr),
    .next_is_null (next_is_null)
  );

  dcf_desc_regs #(.DW(DW)) u_desc (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_evt    (cap_evt),
    .cap_idx    (word_idx),
    .cap_data   (mem_rdata),
    .launch_evt (launch_evt),
    .out_word0  (out_word0),
    .out_paddr  (eng_paddr),
    .out_maddr  (eng_maddr),
    .next_word  (next_word)
  );

  dcf_done_flag u_done (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_evt    (end_evt),
    .clr_strobe (done_clr),
    .flag       (done_irq)
  );

  assign mem_req  = (state == ST_FETCH);
  assign mem_addr = fetch_addr;
  assign eng_cnt  = out_word0[CNT_W-1:0];
  assign eng_ctrl = out_word0[CNT_W +: CTRL_W];

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          done_clr,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          eng_start,
  input logic          done_irq,
  input logic          open_evt,
  input logic          launch_evt,
  input logic          follow_evt,
  input logic          end_evt
);

  p_no_spurious_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && !open_evt && !follow_evt) |=> !mem_req);

  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && chan_en) |=> (mem_req && $stable(mem_addr)));

  p_addr_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_start_follows_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> eng_start);

  p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_follow_fetches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    follow_evt |=> mem_req);

  p_end_sets_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> done_irq);

  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> $past(end_evt));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !done_clr) |=> done_irq);

  p_disable_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!mem_req && !eng_start));

endmodule

bind desc_chain_fetch dcf_checker #(.AW(AW)) u_dcf_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_en    (chan_en),
  .done_clr   (done_clr),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .eng_start  (eng_start),
  .done_irq   (done_irq),
  .open_evt   (open_evt),
  .launch_evt (launch_evt),
  .follow_evt (follow_evt),
  .end_evt    (end_evt)
);

// File: tb/test_desc_chain_fetch.sv
module test_desc_chain_fetch;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_en, chan_en, ptr_wr, done_clr, mem_ack, eng_cnt_zero;
  logic [CNT_W-1:0] chan_cnt;
  logic [AW-1:0] ptr_wdata, mem_addr;
  logic [DW-1:0] mem_rdata, eng_paddr, eng_maddr;
  logic mem_req, eng_start, done_irq;
  logic [DW-CNT_W-1:0] eng_ctrl;
  logic [CNT_W-1:0] eng_cnt;

  always #4 clk = ~clk;

  desc_chain_fetch #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) i_desc_chain_fetch (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .chan_en(chan_en),
    .chan_cnt(chan_cnt), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .done_clr(done_clr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .eng_start(eng_start),
    .eng_ctrl(eng_ctrl), .eng_cnt(eng_cnt), .eng_paddr(eng_paddr),
    .eng_maddr(eng_maddr), .eng_cnt_zero(eng_cnt_zero), .done_irq(done_irq)
  );

  int vectors = 0;
  int miscompares = 0;
  bit cmp_en = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory and engine environment
  logic [31:0] mem [0:255];
  int mem_lat = 1;
  int wait_cnt = 0;
  int eng_len = 2;
  int eng_left = 0;
  bit eng_poke = 0;
  logic [31:0] rd_log[$];
  int starts = 0;
  bit saw_done = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 0; mem_rdata = '0; wait_cnt = 0; eng_cnt_zero = 0; eng_left = 0;
    end else begin
      mem_ack = 0;
      if (mem_req) begin
        if (wait_cnt >= mem_lat) begin
          mem_ack = 1;
          mem_rdata = mem[mem_addr[9:2]];
          rd_log.push_back(mem_addr);
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end else begin
        wait_cnt = 0;
      end
      eng_cnt_zero = eng_poke;
      if (eng_start) begin
        eng_left = eng_len;
        starts++;
      end else if (eng_left > 0) begin
        eng_left--;
        if (eng_left == 0) eng_cnt_zero = 1;
      end
      if (done_irq) saw_done = 1;
    end
  end

  // Behavioural reference model: 0 idle, 1 fetching, 2 waiting on engine
  int m_state, m_idx;
  logic [31:0] m_ptr, m_cur, m_o0, m_o1, m_o2;
  logic [31:0] m_w[4];
  bit m_start, m_done, m_enq;

  always @(posedge clk) begin
    bit launch, fin;
    launch = 0; fin = 0;
    if (!rst_n) begin
      m_state = 0; m_idx = 0; m_ptr = 0; m_cur = 0; m_o0 = 0; m_o1 = 0; m_o2 = 0;
      for (int i = 0; i < 4; i++) m_w[i] = 0;
      m_start = 0; m_done = 0; m_enq = 0;
    end else begin
      case (m_state)
        0: if (chan_en && !m_enq && link_en && chan_cnt == 0) begin
             m_cur = m_ptr & ~32'h3; m_idx = 0; m_state = 1;
           end
        1: if (!chan_en) m_state = 0;
           else if (mem_ack) begin
             m_w[m_idx] = mem_rdata;
             if (m_idx == 3) begin
               launch = 1; m_state = 2;
               m_o0 = m_w[0]; m_o1 = m_w[1]; m_o2 = m_w[2];
             end else m_idx++;
           end
        default: if (!chan_en) m_state = 0;
           else if (eng_cnt_zero) begin
             if ((m_w[3] >> 2) != 0) begin
               m_cur = m_w[3] & ~32'h3; m_idx = 0; m_state = 1;
             end else begin
               m_state = 0; fin = 1;
             end
           end
      endcase
      if (fin) m_done = 1;
      else if (done_clr) m_done = 0;
      m_start = launch;
      m_enq = chan_en;
      if (ptr_wr) m_ptr = ptr_wdata;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R3", "mem_req", {31'b0, mem_req}, {31'b0, m_state == 1});
      if (m_state == 1) chk("R3", "mem_addr", mem_addr, m_cur + 32'(4 * m_idx));
      chk("R5", "eng_start", {31'b0, eng_start}, {31'b0, m_start});
      chk("R5", "eng_cnt", {16'b0, eng_cnt}, {16'b0, m_o0[15:0]});
      chk("R5", "eng_ctrl", {16'b0, eng_ctrl}, {16'b0, m_o0[31:16]});
      chk("R5", "eng_paddr", eng_paddr, m_o1);
      chk("R5", "eng_maddr", eng_maddr, m_o2);
      chk("R8", "done_irq", {31'b0, done_irq}, {31'b0, m_done});
    end
  end

  task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    mem[a[9:2]] = w0; mem[a[9:2] + 1] = w1; mem[a[9:2] + 2] = w2; mem[a[9:2] + 3] = w3;
  endtask

  task automatic write_ptr(input logic [31:0] v);
    @(negedge clk); ptr_wr = 1; ptr_wdata = v;
    @(negedge clk); ptr_wr = 0;
  endtask

  task automatic clear_done();
    @(negedge clk); done_clr = 1;
    @(negedge clk); done_clr = 0;
  endtask

  task automatic reset_log();
    rd_log.delete(); starts = 0; saw_done = 0;
  endtask

  task automatic wait_done(input string req, input int limit);
    int n = 0;
    while (!done_irq && n < limit) begin @(negedge clk); n++; end
    chk(req, "done_irq reached", {31'b0, done_irq}, 32'd1);
  endtask

  task automatic check_reads(input string req, input int nd, input logic [31:0] b0,
                             input logic [31:0] b1, input logic [31:0] b2);
    logic [31:0] bases[3];
    bases[0] = b0; bases[1] = b1; bases[2] = b2;
    chk(req, "read count", rd_log.size(), 32'(4 * nd));
    if (rd_log.size() == 4 * nd)
      for (int i = 0; i < 4 * nd; i++)
        chk(req, "read address", rd_log[i], bases[i / 4] + 32'(4 * (i % 4)));
  endtask

  initial begin
    int n;
    link_en = 0; chan_en = 0; chan_cnt = 0; ptr_wr = 0; ptr_wdata = 0; done_clr = 0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    put_desc(32'h040, 32'h00A5_0003, 32'h4000_1000, 32'h2000_0000, 32'h0000_0100);
    put_desc(32'h100, 32'h0112_0010, 32'h4000_2000, 32'h2000_0400, 32'h0000_0201);
    put_desc(32'h200, 32'h0F00_0001, 32'h4000_3000, 32'h2000_0800, 32'h0000_0000);
    put_desc(32'h300, 32'h7E3C_ABCD, 32'h4000_4000, 32'h2000_0C00, 32'h0000_0003);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "mem_req in reset", {31'b0, mem_req}, 0);
    chk("R1", "eng_start in reset", {31'b0, eng_start}, 0);
    chk("R1", "done_irq in reset", {31'b0, done_irq}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "mem_req after reset", {31'b0, mem_req}, 0);
    chk("R1", "eng_cnt after reset", {16'b0, eng_cnt}, 0);
    chk("R1", "done_irq after reset", {31'b0, done_irq}, 0);
    cmp_en = 1;

    // R2: no start without linking or with a non-zero count
    write_ptr(32'h040);
    reset_log();
    @(negedge clk); chan_en = 1;
    repeat (6) @(negedge clk);
    chk("R2", "reads with linking off", rd_log.size(), 0);
    chan_en = 0; link_en = 1; chan_cnt = 16'd5;
    @(negedge clk); chan_en = 1;
    repeat (6) @(negedge clk);
    chk("R2", "reads with count non-zero", rd_log.size(), 0);
    chan_en = 0; chan_cnt = 0;
    @(negedge clk);

    // R3 R5 R6 R7 R4: three-descriptor chain, middle next pointer has low bits set
    reset_log(); mem_lat = 2; eng_len = 3;
    chan_en = 1;
    wait_done("R7", 500);
    check_reads("R6", 3, 32'h040, 32'h100, 32'h200);
    chk("R5", "start pulses", starts, 3);
    n = rd_log.size();
    repeat (8) @(negedge clk);
    chk("R2", "no restart while enable held", rd_log.size(), n);
    chk("R8", "flag still set", {31'b0, done_irq}, 1);
    chan_en = 0;
    clear_done();
    chk("R8", "flag cleared", {31'b0, done_irq}, 0);

    // R4: software pointer low bits ignored, next pointer 0x3 ends chain
    write_ptr(32'h302);
    reset_log(); mem_lat = 0; eng_len = 1;
    @(negedge clk); chan_en = 1;
    wait_done("R4", 200);
    check_reads("R4", 1, 32'h300, 32'h0, 32'h0);
    chan_en = 0;
    clear_done();

    // R8: clear held through the whole run coincides with completion
    write_ptr(32'h200);
    reset_log(); mem_lat = 1; eng_len = 2;
    @(negedge clk); done_clr = 1; chan_en = 1;
    repeat (30) @(negedge clk);
    chk("R8", "set wins over coincident clear", {31'b0, saw_done}, 1);
    chk("R8", "cleared afterwards", {31'b0, done_irq}, 0);
    done_clr = 0; chan_en = 0;
    @(negedge clk);

    // R9: disable during a fetch
    write_ptr(32'h040);
    reset_log(); mem_lat = 6;
    @(negedge clk); chan_en = 1;
    repeat (3) @(negedge clk);
    chan_en = 0;
    repeat (10) @(negedge clk);
    chk("R9", "no start after fetch abort", starts, 0);
    chk("R9", "no read after fetch abort", rd_log.size(), 0);
    chk("R9", "no flag after fetch abort", {31'b0, done_irq}, 0);

    // R9 R10: disable during a transfer, engine zero then arrives while idle
    reset_log(); mem_lat = 1; eng_len = 30;
    @(negedge clk); chan_en = 1;
    n = 0;
    while (starts == 0 && n < 100) begin @(negedge clk); n++; end
    chan_en = 0;
    repeat (40) @(negedge clk);
    chk("R9", "reads before transfer abort", rd_log.size(), 4);
    chk("R10", "late engine zero ignored", {31'b0, done_irq}, 0);
    chk("R9", "idle after transfer abort", {31'b0, mem_req}, 0);

    // R10: stray engine-zero pulses during a fetch
    write_ptr(32'h300);
    reset_log(); mem_lat = 3; eng_len = 2;
    @(negedge clk); chan_en = 1; eng_poke = 1;
    repeat (8) @(negedge clk);
    eng_poke = 0;
    wait_done("R10", 200);
    check_reads("R10", 1, 32'h300, 32'h0, 32'h0);
    chk("R10", "single start", starts, 1);
    chan_en = 0;
    clear_done();
    @(negedge clk); eng_poke = 1;
    repeat (3) @(negedge clk);
    eng_poke = 0;
    @(negedge clk);
    chk("R10", "idle engine zero no flag", {31'b0, done_irq}, 0);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule